// File: doc/BRIEF.md
# SPI Host Byte Transfer Engine

This block runs one byte-wide SPI transfer as the bus host. A short control register selects the SCK idle level, whether output data moves on the leading or the trailing SCK edge, whether incoming data is captured mid-bit or at the end of the bit, whether the first SCK edge follows select assertion right away, and whether each of the select, data-in and data-out lines is inverted.

A one-cycle `start` pulse loads `txByte`, asserts the select line and begins toggling SCK. The half-period of SCK, in system clocks, is `baudDiv + 1`. Eight bits go out MSB first while eight come in. After the last SCK edge the line rests at its idle level for one half-period. Select then deasserts, `done` pulses and `rxByte` holds the received byte. `busy` covers the transfer. While it is high, control writes and further start pulses are ignored.

Control register layout (`cfgWdata` / `cfgRdata`): bit 7 end-of-bit sampling, bit 6 trailing-edge data change, bit 5 SCK idle high, bit 4 fast start, bit 3 always 0, bit 2 select active-low, bit 1 invert data-in, bit 0 invert data-out.

Top module: `spi_host_engine`

## Requirements
- R1: After reset, `cfgRdata` is 0x04, `sck` is 0, `ssOut` is 1, `sdo` is 0, and `busy` and `done` are 0.
- R2: A `cfgWe` write while idle stores bits 7..4 and 2..0 of `cfgWdata`, and bit 3 reads back as 0. A write while `busy` is high leaves `cfgRdata` unchanged.
- R3: While idle, `sck` equals bit 5. Each transfer makes exactly 16 `sck` transitions and ends with `sck` at the idle level.
- R4: With H = `baudDiv`+1, consecutive `sck` transitions are H clocks apart. The first transition comes 1 clock after the start edge if bit 4 is set, and H clocks after it if bit 4 is clear.
- R5: `done` pulses for one cycle H clocks after the 16th `sck` transition. In the same cycle `busy` falls and select deasserts.
- R6: `sdo` shows `txByte` MSB first, XORed with bit 0, from select assertion. With bit 6 set, the next bit appears on transitions 2,4,..,14. With bit 6 clear, it appears on transitions 3,5,..,15. While idle, `sdo` equals bit 0.
- R7: Received bit k (k=0 first, stored MSB first) is `sdi` XOR bit 1, captured at tick F+2k. Tick n is the n-th SCK transition, and tick 17 is the closing tick. F = 1 with bit 6 set, or 2 with bit 6 clear, plus 1 when bit 7 is set.
- R8: While idle, `ssOut` equals bit 2. During a transfer it is the inverse of bit 2.
- R9: A `start` pulse while `busy` is high is ignored: the transfer's timing is unchanged and `busy` stays low after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Control register write strobe |
| cfgWdata | input | 8 | Control register write value |
| cfgRdata | output | 8 | Control register contents |
| baudDiv | input | DIV_W | SCK half-period minus one, in system clocks |
| start | input | 1 | Begin a transfer |
| txByte | input | DATA_W | Byte to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rxByte | output | DATA_W | Received byte, valid from `done` |
| sck | output | 1 | Serial clock |
| ssOut | output | 1 | Client select |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The assertions assume that `baudDiv` is held steady for the whole of a transfer, because the half-period spacing is only defined for a constant divider. They also assume that the client changes `sdi` only after an SCK transition, never in the same system clock. The bench sets the divider before each start and leaves it alone until `done`. It updates `sdi` on the falling system-clock edge after it sees each SCK transition, driving a per-transfer pattern indexed by the transition count. The captured byte therefore shows which transition was used for sampling.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  // Control fields, in register bit order 7..4 then 2..0
  typedef struct packed {
    logic smpEnd;     // capture at end of bit time
    logic edgeTrail;  // data moves on active-to-idle SCK edge
    logic sckIdleHi;  // SCK rests high
    logic fastStart;  // first SCK edge one clock after select
    logic selLow;     // select is active low
    logic sdiInv;     // invert received data
    logic sdoInv;     // invert transmitted data
  } cfg_t;

  // Strobes from sequencer to datapath
  typedef struct packed {
    logic load;
    logic toggle;
    logic shift;
    logic sample;
    logic finish;
  } strobe_t;

  localparam cfg_t CFG_RESET = '{selLow: 1'b1, default: 1'b0};

endpackage

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  cfg_t             cfgWval,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             start,
  output cfg_t             cfg,
  output strobe_t          stb,
  output logic             busy,
  output logic             done
);

  localparam int EDGES = 2 * DATA_W;
  localparam int CNT_W = $clog2(EDGES + 2);
  localparam logic [CNT_W-1:0] C_ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_TWO      = CNT_W'(2);
  localparam logic [CNT_W-1:0] C_THREE    = CNT_W'(3);
  localparam logic [CNT_W-1:0] LAST_EDGE  = CNT_W'(EDGES);
  localparam logic [CNT_W-1:0] LAST_TRAIL = CNT_W'(EDGES - 2);
  localparam logic [CNT_W-1:0] LAST_LEAD  = CNT_W'(EDGES - 1);
  localparam logic [CNT_W-1:0] SPAN       = CNT_W'(2 * (DATA_W - 1));

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] tickNum;
  logic [CNT_W-1:0] firstSmp;
  logic [CNT_W-1:0] smpDist;
  logic             tick;

  // Control register; frozen while a transfer runs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cfg <= CFG_RESET;
    else if (cfgWe && !busy)  cfg <= cfgWval;
  end

  always_comb begin
    tick     = busy && (divCnt == '0);
    tickNum  = edgeCnt + C_ONE;
    firstSmp = (cfg.edgeTrail ? C_ONE : C_TWO) + {{(CNT_W-1){1'b0}}, cfg.smpEnd};
    smpDist  = tickNum - firstSmp;

    stb.load   = start && !busy;
    stb.toggle = tick && (edgeCnt != LAST_EDGE);
    stb.finish = tick && (edgeCnt == LAST_EDGE);
    stb.sample = tick && (tickNum >= firstSmp) && (smpDist <= SPAN) && !smpDist[0];
    if (cfg.edgeTrail)
      stb.shift = tick && !tickNum[0] && (tickNum >= C_TWO) && (tickNum <= LAST_TRAIL);
    else
      stb.shift = tick && tickNum[0] && (tickNum >= C_THREE) && (tickNum <= LAST_LEAD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else begin
      done <= stb.finish;
      if (stb.load) begin
        busy    <= 1'b1;
        divCnt  <= cfg.fastStart ? '0 : baudDiv;
        edgeCnt <= '0;
      end else if (stb.finish) begin
        busy <= 1'b0;
      end else if (stb.toggle) begin
        edgeCnt <= edgeCnt + C_ONE;
        divCnt  <= baudDiv;
      end else if (busy) begin
        divCnt <= divCnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_eng_dp.sv
module spi_eng_dp
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              sckIdleHi,
  input  logic              selLow,
  input  logic              sdiInv,
  input  logic              sdoInv,
  input  logic [DATA_W-1:0] txByte,
  input  logic              sdi,
  output logic              sck,
  output logic              ssOut,
  output logic              sdo,
  output logic [DATA_W-1:0] rxByte
);

  logic [DATA_W-1:0] txSh;
  logic [DATA_W-1:0] rxSh;
  logic              sckAct;
  logic              ssAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh   <= '0;
      rxSh   <= '0;
      sckAct <= 1'b0;
      ssAct  <= 1'b0;
    end else if (stb.load) begin
      txSh   <= txByte;
      rxSh   <= '0;
      sckAct <= 1'b0;
      ssAct  <= 1'b1;
    end else begin
      if (stb.toggle) sckAct <= ~sckAct;
      if (stb.shift)  txSh   <= {txSh[DATA_W-2:0], 1'b0};
      if (stb.sample) rxSh   <= {rxSh[DATA_W-2:0], sdi ^ sdiInv};
      if (stb.finish) ssAct  <= 1'b0;
    end
  end

  assign sck    = sckAct ^ sckIdleHi;
  assign ssOut  = ssAct ^ selLow;
  assign sdo    = (ssAct & txSh[DATA_W-1]) ^ sdoInv;
  assign rxByte = rxSh;

endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_eng_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic              start,
  input  logic [DATA_W-1:0] txByte,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxByte,
  output logic              sck,
  output logic              ssOut,
  output logic              sdo,
  input  logic              sdi
);

  cfg_t    cfg;
  strobe_t stb;
  logic    unusedSpareBit;

  assign unusedSpareBit = cfgWdata[3];

  spi_eng_ctrl #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgWval (cfg_t'({cfgWdata[7:4], cfgWdata[2:0]})),
    .baudDiv (baudDiv),
    .start   (start),
    .cfg     (cfg),
    .stb     (stb),
    .busy    (busy),
    .done    (done)
  );

  spi_eng_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .sckIdleHi (cfg.sckIdleHi),
    .selLow    (cfg.selLow),
    .sdiInv    (cfg.sdiInv),
    .sdoInv    (cfg.sdoInv),
    .txByte    (txByte),
    .sdi       (sdi),
    .sck       (sck),
    .ssOut     (ssOut),
    .sdo       (sdo),
    .rxByte    (rxByte)
  );

  assign cfgRdata = {cfg.smpEnd, cfg.edgeTrail, cfg.sckIdleHi, cfg.fastStart,
                     1'b0, cfg.selLow, cfg.sdiInv, cfg.sdoInv};

endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWe,
  input logic       busy,
  input logic       done,
  input logic       sck,
  input logic       ssOut,
  input logic [7:0] cfgRdata
);

  // R2
  spare_bit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdata[3] == 1'b0);

  // R2
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfgWe) |=> $stable(cfgRdata));

  // R3
  sck_idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sck == cfgRdata[5]));

  // R8
  sel_idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ssOut == cfgRdata[2]));

  // R8
  sel_active_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (ssOut != cfgRdata[2]));

  // R5
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind spi_host_engine spi_eng_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWe    (cfgWe),
  .busy     (busy),
  .done     (done),
  .sck      (sck),
  .ssOut    (ssOut),
  .cfgRdata (cfgRdata)
);

// File: tb/test_spi_host_engine.sv
module test_spi_host_engine;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [7:0] cfgWdata = '0;
  logic [7:0] cfgRdata;
  logic [7:0] baudDiv = '0;
  logic       start = 1'b0;
  logic [7:0] txByte = '0;
  logic       busy, done, sck, ssOut, sdo;
  logic [7:0] rxByte;
  logic       sdi = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #5 clk = ~clk;

  spi_host_engine i_spi_host_engine (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .baudDiv(baudDiv), .start(start), .txByte(txByte),
    .busy(busy), .done(done), .rxByte(rxByte), .sck(sck), .ssOut(ssOut),
    .sdo(sdo), .sdi(sdi)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL R5 watchdog expired: actual %0d expected below 150000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // c: bit6 end sample, bit5 trailing change, bit4 idle high, bit3 fast,
  //    bit2 select low, bit1 sdi invert, bit0 sdo invert
  task automatic runXfer(input logic [6:0] c, input int div, input logic [7:0] tx,
                         input logic [16:0] w, input bit poke);
    logic [7:0] cfgByte;
    logic [7:0] expRx;
    logic smp, cke, ckp, fst, ssp, sdip, sdop;
    int h, lead, t, edges, timeErr, sdoErr, ssErr, firstSmp, j;
    logic prev;
    cfgByte = {c[6:3], 1'b0, c[2:0]};
    {smp, cke, ckp, fst, ssp, sdip, sdop} = c;
    h = div + 1;
    lead = fst ? 1 : h;
    baudDiv = 8'(div);
    writeCfg(cfgByte);
    check(cfgRdata == cfgByte, "R2", "readback", cfgRdata, cfgByte);
    check(sck == ckp, "R3", "idle sck", sck, ckp);
    check(ssOut == ssp, "R8", "idle select", ssOut, ssp);
    check(sdo == sdop, "R6", "idle sdo", sdo, sdop);
    @(negedge clk);
    start = 1'b1;
    txByte = tx;
    sdi = w[0];
    @(negedge clk);
    start = 1'b0;
    t = 0; edges = 0; timeErr = 0; sdoErr = 0; ssErr = 0;
    prev = sck;
    check(sdo == (tx[7] ^ sdop), "R6", "first bit at select", sdo, tx[7] ^ sdop);
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
      if (poke && t == 3) begin
        cfgWe = 1'b1;
        cfgWdata = ~cfgByte;
        start = 1'b1;
      end else begin
        cfgWe = 1'b0;
        start = 1'b0;
      end
      if (sck != prev) begin
        edges++;
        prev = sck;
        if (t != lead + (edges - 1) * h) timeErr++;
        if (cke) j = (edges / 2 > 7) ? 7 : edges / 2;
        else     j = (edges - 1) / 2;
        if (sdo !== (tx[7 - j] ^ sdop)) sdoErr++;
      end
      if (!done && ssOut !== ~ssp) ssErr++;
      sdi = w[(edges > 16) ? 16 : edges];
    end
    firstSmp = (cke ? 1 : 2) + int'(smp);
    for (int k = 0; k < 8; k++) expRx[7 - k] = w[firstSmp + 2 * k - 1] ^ sdip;
    check(timeErr == 0, "R4", "sck edge timing errors", timeErr, 0);
    check(edges == 16, "R3", "sck transitions", edges, 16);
    check(t == lead + 16 * h, "R5", "done time", t, lead + 16 * h);
    check(!busy && ssOut == ssp, "R5", "busy/select at done", {busy, ssOut}, {1'b0, ssp});
    check(sck == ckp, "R3", "sck at end", sck, ckp);
    check(sdoErr == 0, "R6", "sdo bit errors", sdoErr, 0);
    check(ssErr == 0, "R8", "select active errors", ssErr, 0);
    check(rxByte == expRx, "R7", "received byte", rxByte, expRx);
    @(negedge clk);
    check(!done && !busy, "R9", "idle after done", {done, busy}, 0);
    if (poke) check(cfgRdata == cfgByte, "R2", "write during busy", cfgRdata, cfgByte);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cfgRdata == 8'h04, "R1", "reset cfg", cfgRdata, 8'h04);
    check(sck == 1'b0 && sdo == 1'b0, "R1", "reset sck/sdo", {sck, sdo}, 0);
    check(ssOut == 1'b1, "R1", "reset select", ssOut, 1);
    check(!busy && !done, "R1", "reset busy/done", {busy, done}, 0);
    // R2 spare bit reads zero
    writeCfg(8'hFF);
    check(cfgRdata == 8'hF7, "R2", "spare bit", cfgRdata, 8'hF7);
    for (int c = 0; c < 128; c++) begin
      for (int d = 0; d <= 2; d += 2) begin
        runXfer(7'(c), d, 8'(c * 29 + d * 7 + 8'h3C),
                17'(c * 1237 + d * 4099 + 17'h1A5B3), (c % 16) == 5);
      end
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule